// File: doc/BRIEF.md
# Dual-Address I2C Register Write Slave

This block sits on a two-wire serial control bus and turns write transfers into word writes for a bank of 16-bit control registers. It watches the SCL and SDA lines through synchronisers clocked by the system clock. It detects start and stop conditions and compares the first byte of each transfer with its own 7-bit device address. When the address matches and the transfer is a write, the block pulls SDA low to acknowledge each byte. The first byte after the address names a register index. Each pair of bytes after that forms one 16-bit word, and the block presents that word on a single-cycle write strobe.

An address-select pin picks one of two device addresses. The main address reaches the whole index range. The sub address reaches only the indices below a parameterised span. An auto-increment pin makes the index step after each word, so one transfer can fill consecutive registers. A resynchronise strap adds one holding register on the write path. With the strap high, each word is latched by the system clock before it is written. With the strap low, the word is written directly. Read transfers and clock stretching are not supported.

Top module: `i2c_dual_addr_regwr`

## Requirements
- R1: While reset is held, and after it is released, `sda_pull` and `wr_en` are low.
- R2: The first byte after a start carries the 7-bit address, MSB first, followed by a direction bit that is 0 for a write. The block acknowledges that byte only when its top seven bits equal `MAIN_ADDR` (when `addr_select`=1) or `SUB_ADDR` (when `addr_select`=0) and the direction bit is 0.
- R3: After an address byte that does not match, or that has direction bit 1, the block acknowledges nothing and writes nothing until the next start condition.
- R4: After a matched address, every byte is acknowledged. `sda_pull` rises after the SCL falling edge that ends the eighth bit, and falls after the SCL falling edge that ends the ninth clock.
- R5: The first byte after the address is the register index. Each following pair of bytes is one word, high byte first, and each completed word produces exactly one write of `{high, low}` to the current index.
- R6: With `auto_inc`=1, the index rises by one after each word and wraps from 0xFF to 0x00. With `auto_inc`=0, every word of the transfer goes to the same index.
- R7: Under the sub address, words aimed at an index of `SUB_SPAN` (default 64) or above are still acknowledged but are not written. Under the main address, every index is written.
- R8: With `resync_en`=0, `wr_en` rises one clock after the clock in which `sda_pull` rises for the acknowledge of the word's low byte. With `resync_en`=1, it rises two clocks after.
- R9: A stop condition ends the transfer. A half-received word is not written, and bytes that follow without a new start are neither acknowledged nor written.
- R10: A repeated start discards any half-received word and returns the block to the address phase.
- R11: `wr_en` is high for exactly one clock per written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 drives SDA low (acknowledge) |
| addr_select | input | 1 | 1 selects main address, 0 selects sub address |
| resync_en | input | 1 | 1 latches each word one extra clock before writing |
| auto_inc | input | 1 | 1 steps the register index after each word |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | IDX_W | Register index of the write |
| wr_data | output | DATA_W | Register word of the write |

## Verification
The bench builds the block with main address 0x5A, sub address 0x2C and a sub span of 64. These values put the boundary between indices 0x3F and 0x40 inside a short auto-incrementing burst, so one transfer shows both the last word that is written and the first word that is dropped. The default two-stage synchronisers and 8-bit index width let a burst starting at 0xFE cross the index wrap. The bench models the acknowledge of every byte and the expected write list from the pin settings. It measures the write latency against the acknowledge edge under both strap values.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_ACK,
      ST_SKIP
   } bus_state_t;

   typedef enum logic [1:0] {
      PH_INDEX,
      PH_HIGH,
      PH_LOW
   } word_phase_t;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic lvl,
   output logic prev
);
   if (STAGES < 2) begin : g_bad_depth
      $error("i2cw_line_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b1;
            else        q <= line_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b1;
            else        q <= g_stage[g-1].q;
      end
   end

   assign lvl = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl;
endmodule

// File: rtl/i2cw_byte_rx.sv
module i2cw_byte_rx
   import i2cw_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_lvl,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              sda_pull,
   output logic              frame_open,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_q
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
      $error("i2cw_byte_rx: address plus direction bit must fill one byte");
   end

   bus_state_t        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              addr_hit;
   logic              byte_full;

   assign addr_hit  = (shreg[BYTE_W-1:1] == dev_addr) && !shreg[0];
   assign byte_full = (bit_cnt == CNT_W'(BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         byte_q     <= '0;
         sda_pull   <= 1'b0;
         frame_open <= 1'b0;
         byte_stb   <= 1'b0;
      end else begin
         frame_open <= 1'b0;
         byte_stb   <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise && !byte_full) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && byte_full) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (addr_hit) begin
                           sda_pull   <= 1'b1;
                           frame_open <= 1'b1;
                           state      <= ST_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        sda_pull <= 1'b1;
                        byte_stb <= 1'b1;
                        byte_q   <= shreg;
                        state    <= ST_ACK;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     state    <= ST_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);                                     // R4
   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_pull && !byte_stb);                    // R3
   AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |=> !byte_stb);                                           // R5
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == ST_IDLE) && !sda_pull);     // R9
endmodule

// File: rtl/i2cw_word_asm.sv
module i2cw_word_asm
   import i2cw_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int DATA_W   = 16,
   parameter int SUB_SPAN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_open,
   input  logic              byte_stb,
   input  logic [BYTE_W-1:0] byte_q,
   input  logic              auto_inc,
   input  logic              resync,
   input  logic              full_access,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);
   localparam int HALF_W = DATA_W / 2;

   if (HALF_W != BYTE_W || DATA_W % 2 != 0) begin : g_bad_data
      $error("i2cw_word_asm: a word must be exactly two bytes");
   end
   if (IDX_W != BYTE_W) begin : g_bad_idx
      $error("i2cw_word_asm: the index must be one byte");
   end
   if (SUB_SPAN < 1 || SUB_SPAN > (1 << IDX_W)) begin : g_bad_span
      $error("i2cw_word_asm: SUB_SPAN out of the index range");
   end

   word_phase_t       phase;
   logic [IDX_W-1:0]  idx_r;
   logic [HALF_W-1:0] hi_r;
   logic              in_span;
   logic              cmt_vld,  hold_vld;
   logic [IDX_W-1:0]  cmt_idx,  hold_idx;
   logic [DATA_W-1:0] cmt_data, hold_data;

   assign in_span = full_access || ({1'b0, idx_r} < (IDX_W+1)'(SUB_SPAN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_INDEX;
         idx_r    <= '0;
         hi_r     <= '0;
         cmt_vld  <= 1'b0;
         cmt_idx  <= '0;
         cmt_data <= '0;
      end else begin
         cmt_vld <= 1'b0;
         if (frame_open) begin
            phase <= PH_INDEX;
         end else if (byte_stb) begin
            case (phase)
               PH_INDEX: begin
                  idx_r <= byte_q;
                  phase <= PH_HIGH;
               end
               PH_HIGH: begin
                  hi_r  <= byte_q;
                  phase <= PH_LOW;
               end
               default: begin
                  cmt_vld  <= in_span;
                  cmt_idx  <= idx_r;
                  cmt_data <= {hi_r, byte_q};
                  if (auto_inc) idx_r <= idx_r + 1'b1;
                  phase <= PH_HIGH;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_idx  <= '0;
         hold_data <= '0;
      end else begin
         hold_vld  <= cmt_vld;
         hold_idx  <= cmt_idx;
         hold_data <= cmt_data;
      end
   end

   always_comb begin
      if (resync) begin
         wr_en   = hold_vld;
         wr_idx  = hold_idx;
         wr_data = hold_data;
      end else begin
         wr_en   = cmt_vld;
         wr_idx  = cmt_idx;
         wr_data = cmt_data;
      end
   end

   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);                                                 // R11
   AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full_access) |-> ({1'b0, wr_idx} < (IDX_W+1)'(SUB_SPAN))); // R7
   AST_RESYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && resync) |-> $past(cmt_vld));                             // R8
endmodule

// File: rtl/i2c_dual_addr_regwr.sv
module i2c_dual_addr_regwr
   import i2cw_pkg::*;
#(
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] MAIN_ADDR   = 7'h5A,
   parameter logic [ADDR_W-1:0] SUB_ADDR    = 7'h2C,
   parameter int                SYNC_STAGES = 2,
   parameter int                IDX_W       = 8,
   parameter int                DATA_W      = 16,
   parameter int                SUB_SPAN    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   input  logic              addr_select,
   input  logic              resync_en,
   input  logic              auto_inc,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);
   if (MAIN_ADDR == SUB_ADDR) begin : g_bad_pair
      $error("i2c_dual_addr_regwr: the two device addresses must differ");
   end

   logic scl_lvl, scl_prev, sda_lvl, sda_prev;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic frame_open, byte_stb;
   logic [BYTE_W-1:0] byte_q;
   logic [ADDR_W-1:0] dev_addr;

   i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_in(scl_in), .lvl(scl_lvl), .prev(scl_prev));
   i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_in(sda_in), .lvl(sda_lvl), .prev(sda_prev));

   assign scl_rise  = scl_lvl && !scl_prev;
   assign scl_fall  = !scl_lvl && scl_prev;
   assign start_det = scl_lvl && scl_prev && sda_prev && !sda_lvl;
   assign stop_det  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
   assign dev_addr  = addr_select ? MAIN_ADDR : SUB_ADDR;

   i2cw_byte_rx #(.ADDR_W(ADDR_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .sda_lvl(sda_lvl), .dev_addr(dev_addr), .sda_pull(sda_pull),
      .frame_open(frame_open), .byte_stb(byte_stb), .byte_q(byte_q));

   i2cw_word_asm #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SUB_SPAN(SUB_SPAN)) u_asm (
      .clk(clk), .rst_n(rst_n), .frame_open(frame_open), .byte_stb(byte_stb),
      .byte_q(byte_q), .auto_inc(auto_inc), .resync(resync_en),
      .full_access(addr_select), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_pull);                                          // R10
   AST_FRAME_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_open |-> sda_pull);                                          // R2
endmodule

// File: tb/tb_i2c_dual_addr_regwr.sv
module tb_i2c_dual_addr_regwr;
   localparam logic [6:0] MAIN_A = 7'h5A;
   localparam logic [6:0] SUB_A  = 7'h2C;
   localparam int SPAN = 64;
   localparam int H    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1;
   logic addr_sel = 1'b1, rsync = 1'b0, ainc = 1'b0;
   logic sda_pull, sda_bus, wr_en;
   logic [7:0]  wr_idx;
   logic [15:0] wr_data;

   assign sda_bus = sda_m & ~sda_pull;

   i2c_dual_addr_regwr #(.MAIN_ADDR(MAIN_A), .SUB_ADDR(SUB_A), .SUB_SPAN(SPAN)) dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_pull(sda_pull), .addr_select(addr_sel), .resync_en(rsync),
      .auto_inc(ainc), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

   int checks = 0, errors = 0;
   bit done = 1'b0;

   int cyc = 0, rise_cyc = 0, dbl = 0;
   logic pull_q = 1'b0, wr_q = 1'b0;
   int got_n = 0, exp_n = 0;
   logic [7:0]  got_idx [64], exp_idx [64];
   logic [15:0] got_dat [64], exp_dat [64];
   int          got_lat [64];

   always @(negedge clk) begin
      cyc++;
      if (sda_pull && !pull_q) rise_cyc = cyc;
      pull_q = sda_pull;
      if (wr_en) begin
         if (got_n < 64) begin
            got_idx[got_n] = wr_idx;
            got_dat[got_n] = wr_data;
            got_lat[got_n] = cyc - rise_cyc;
         end
         got_n++;
      end
      if (wr_en && wr_q) dbl++;
      wr_q = wr_en;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit exp_ack(input logic [6:0] a, input bit rw, input bit sel);
      return !rw && (a == (sel ? MAIN_A : SUB_A));
   endfunction

   function automatic bit exp_store(input logic [7:0] idx, input bit sel);
      return sel || (int'(idx) < SPAN);
   endfunction

   task automatic do_start();
      sda_m = 1'b1; wt(H);
      scl_m = 1'b1; wt(H);
      sda_m = 1'b0; wt(H);
      scl_m = 1'b0; wt(H);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wt(H);
      scl_m = 1'b1; wt(H);
      sda_m = 1'b1; wt(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wt(H);
         scl_m = 1'b1; wt(H);
         scl_m = 1'b0; wt(2);
      end
      sda_m = 1'b1; wt(H);
      scl_m = 1'b1; wt(H/2);
      ack = sda_pull;
      wt(H/2);
      scl_m = 1'b0; wt(H);
   endtask

   task automatic clear_log();
      got_n = 0;
      exp_n = 0;
   endtask

   task automatic push_exp(input logic [7:0] idx, input logic [15:0] d);
      exp_idx[exp_n] = idx;
      exp_dat[exp_n] = d;
      exp_n++;
   endtask

   task automatic compare(input string req, input bit rs);
      chk(got_n == exp_n, {req, " write count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         chk(got_idx[i] == exp_idx[i], {req, " index"}, got_idx[i], exp_idx[i]);
         chk(got_dat[i] == exp_dat[i], {req, " word"}, got_dat[i], exp_dat[i]);
         chk(got_lat[i] == (rs ? 2 : 1), "R8 latency", got_lat[i], rs ? 2 : 1);
      end
   endtask

   task automatic run_txn(input logic [6:0] a, input bit rw, input bit sel, input bit inc,
                          input bit rs, input logic [7:0] idx0, input int nw, input string req);
      bit ack, hit;
      logic [7:0] idx, hi, lo;
      addr_sel = sel; ainc = inc; rsync = rs;
      wt(4);
      clear_log();
      hit = exp_ack(a, rw, sel);
      do_start();
      send_byte({a, rw}, ack);
      chk(ack == hit, {req, " R2 address ack"}, ack, hit);
      send_byte(idx0, ack);
      chk(ack == hit, {req, " R4 index ack"}, ack, hit);
      idx = idx0;
      for (int w = 0; w < nw; w++) begin
         hi = 8'($urandom());
         lo = 8'($urandom());
         send_byte(hi, ack);
         chk(ack == hit, {req, " R4 high ack"}, ack, hit);
         send_byte(lo, ack);
         chk(ack == hit, {req, " R4 low ack"}, ack, hit);
         if (hit && exp_store(idx, sel)) push_exp(idx, {hi, lo});
         if (inc) idx = idx + 8'd1;
      end
      do_stop();
      wt(6);
      compare(req, rs);
   endtask

   initial begin
      bit ack;
      logic [6:0] ra;
      bit rsel;
      void'($urandom(32'd2024));
      wt(3);
      chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
      chk(wr_en == 1'b0, "R1 strobe in reset", wr_en, 0);
      rst_n = 1'b1;
      wt(5);
      chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
      chk(wr_en == 1'b0, "R1 strobe after reset", wr_en, 0);

      run_txn(MAIN_A, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 3, "R5 R6 fixed index");
      run_txn(MAIN_A, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFE, 3, "R6 wrap");
      run_txn(SUB_A,  1'b0, 1'b0, 1'b1, 1'b0, 8'h3E, 3, "R7 sub span edge");
      run_txn(MAIN_A, 1'b0, 1'b1, 1'b1, 1'b0, 8'h7E, 2, "R7 main full range");
      run_txn(7'h11,  1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 2, "R3 foreign address");
      run_txn(MAIN_A, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 1, "R3 read direction");
      run_txn(SUB_A,  1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 1, "R2 sub while main");
      run_txn(MAIN_A, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 1, "R2 main while sub");
      run_txn(MAIN_A, 1'b0, 1'b1, 1'b1, 1'b1, 8'h20, 3, "R8 resync");

      // R9: half word then stop, then bytes with no start
      addr_sel = 1'b1; rsync = 1'b0; ainc = 1'b0;
      wt(4); clear_log();
      do_start();
      send_byte({MAIN_A, 1'b0}, ack);
      chk(ack == 1'b1, "R9 address ack", ack, 1);
      send_byte(8'h30, ack);
      send_byte(8'h77, ack);
      do_stop();
      wt(4);
      send_byte(8'hA5, ack);
      chk(ack == 1'b0, "R9 byte after stop", ack, 0);
      send_byte(8'h3C, ack);
      chk(ack == 1'b0, "R9 second byte after stop", ack, 0);
      wt(6);
      chk(got_n == 0, "R9 no write", got_n, 0);

      // R10: repeated start drops the half word
      wt(4); clear_log();
      do_start();
      send_byte({MAIN_A, 1'b0}, ack);
      send_byte(8'h31, ack);
      send_byte(8'h12, ack);
      do_start();
      send_byte({MAIN_A, 1'b0}, ack);
      chk(ack == 1'b1, "R10 address ack after restart", ack, 1);
      send_byte(8'h32, ack);
      send_byte(8'hAB, ack);
      send_byte(8'hCD, ack);
      do_stop();
      wt(6);
      push_exp(8'h32, 16'hABCD);
      compare("R10 restart", 1'b0);

      for (int k = 0; k < 14; k++) begin
         rsel = 1'($urandom());
         ra = ($urandom() % 5 == 0) ? 7'($urandom()) : (rsel ? MAIN_A : SUB_A);
         run_txn(ra, 1'b0, rsel, 1'($urandom()), 1'($urandom()),
                 8'($urandom()), 1 + int'($urandom() % 3), "R5 random");
      end

      chk(dbl == 0, "R11 strobe width", dbl, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R5 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule